// File: doc/BRIEF.md
# Wake-Source Aggregator and Reset-Cause Controller

This block decides when a sleeping chip wakes and whether the processor restarts as part of that wake. Software writes a low-power mode code and raises a sleep request strobe. The block then looks up which power domains stay powered in that mode and enables only the wake inputs those domains own. It also latches whether the mode is a deep one. The raw wake inputs are grouped by owning domain: always-on pins, a hibernate real-time-clock timer, hibernate-core interrupts, and core-domain timers plus one selectable pin.

When any enabled input is seen high while asleep, the block leaves sleep with a one-cycle wake pulse. For deep modes it also holds the processor reset for a fixed number of cycles. It records every enabled source that was active at that moment in a sticky event register. Software reads that register after reset and clears bits by writing ones. The mode-to-domain table can be rewritten by software, so the enable mask is a property of the mode rather than a fixed list.

Top module: `wake_reset_ctrl`

## Requirements
- R1: A one-cycle `sleepReq` while idle makes `sleepActive` high from the next rising edge. The mode code, the selected core pin and the enable mask are latched at that edge.
- R2: The enable mask is the union of the wake sources of every domain whose bit is set in the table entry for the latched mode. Domain bits are: bit 0 always-on pins, bit 1 RTC timer, bit 2 hibernate-core interrupts, bit 3 core timers and selected pin. A source of an unpowered domain never wakes the block and never sets an event bit.
- R3: Mode code bit 5 set means hibernate, with bits 4:0 the level. Supported codes are sleep levels 0 to 7 and 31 and hibernate levels 0 to 2. Any other code behaves as sleep level 0, using its table entry and no processor reset.
- R4: Waking from sleep levels 0 to 3 gives `wakePulse` high for exactly one cycle, keeps `cpuReset` low, and returns to idle.
- R5: Waking from sleep levels 4 to 7 and 31, or from any supported hibernate level, raises `cpuReset` in the same cycle as `wakePulse` and holds it for exactly 4 consecutive cycles.
- R6: Each wake input passes a two-flop synchronizer. An input driven high between edges while asleep gives `wakePulse` after the third rising edge.
- R7: Wake inputs that are high while the block is not asleep cause no wake pulse, no reset and no event bit.
- R8: Event register layout: bits 3:0 are always-on pins 0 to 3, bit 4 is the RTC timer, and bits 8:5 are hibernate interrupts (motion, brown-out, comparator 0, comparator 1). Bit 9 is the radio sleep timer, bit 10 the sleep timer and bit 11 the selected core pin. Every enabled source high in the wake cycle is captured, and the bits stay set until cleared.
- R9: A one-cycle `evtClr` clears exactly the event bits at which it holds ones and leaves the others unchanged.
- R10: A table write with `tblWrEn` stores `tblWrMask` in the entry for `tblWrMode` when that code is supported. Writes to unsupported codes are ignored. After reset every entry has all four domains powered.
- R11: Only the core pin chosen by `corePinSel` (latched at sleep entry) acts as the core pin wake source. The other core pins are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | Sleep request strobe |
| modeCode | input | 6 | Low-power mode code: bit 5 selects hibernate, bits 4:0 the level |
| tblWrEn | input | 1 | Table write strobe |
| tblWrMode | input | 6 | Mode code whose table entry is written |
| tblWrMask | input | 4 | Domain-powered mask to store |
| corePinSel | input | 3 | Selects which core pin can wake |
| aonPins | input | 4 | Always-on pin wake inputs |
| rtcWake | input | 1 | Hibernate RTC timer wake |
| hbnIrq | input | 4 | Hibernate-core interrupts: motion, brown-out, comparator 0, comparator 1 |
| radioTmrWake | input | 1 | Radio sleep-timer wake |
| sleepTmrWake | input | 1 | Sleep-timer wake |
| corePins | input | 8 | Core-domain pin wake candidates |
| evtClr | input | 12 | Write-one-to-clear strobes for the event register |
| wakePulse | output | 1 | One-cycle wake request |
| cpuReset | output | 1 | Processor reset pulse for deep wakes |
| sleepActive | output | 1 | High while the block waits for a wake event |
| evtReg | output | 12 | Sticky wake-cause register |

## Verification
The wake path is driven from a single source in each domain, from two domains' sources in the same cycle, and from sources held high in unpowered domains before an enabled one rises. This separates a correct per-mode union from a mask that ignores the table, and it also tests capture of several sources at once. Shallow, deep-sleep, level-31, hibernate and unsupported codes are each paired with a different source, so a wrong reset decision or a wrong slot lookup shows as a reset length or an event value that differs from the expected one. Inputs held high while idle, and a core pin other than the selected one, check the two ways a wake must be refused.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int MODE_W    = 6;
  localparam int DOM_W     = 4;
  localparam int NUM_SLOTS = 12;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_WAKE    = 2'd2,
    ST_RSTHOLD = 2'd3
  } wake_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchMode;
    logic capture;
  } ctrl_strobe_t;

  typedef struct packed {
    logic              ok;
    logic              deep;
    logic [SLOT_W-1:0] slot;
  } mode_dec_t;

  // Map a mode code to a table slot: sleep 0..7 -> 0..7, sleep 31 -> 8,
  // hibernate 0..2 -> 9..11.
  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
    mode_dec_t d;
    d = '0;
    if (m[5]) begin
      if (m[4:0] <= 5'd2) begin
        d.ok   = 1'b1;
        d.deep = 1'b1;
        d.slot = SLOT_W'(9) + SLOT_W'(m[1:0]);
      end
    end else if (m[4:0] <= 5'd7) begin
      d.ok   = 1'b1;
      d.deep = m[2];
      d.slot = SLOT_W'(m[2:0]);
    end else if (m[4:0] == 5'd31) begin
      d.ok   = 1'b1;
      d.deep = 1'b1;
      d.slot = SLOT_W'(8);
    end
    return d;
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int AON_PINS    = 4,
  parameter int HBN_IRQS    = 4,
  parameter int CORE_PINS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strobe_t                   strobes,
  input  logic [MODE_W-1:0]              modeCode,
  input  logic                           tblWrEn,
  input  logic [MODE_W-1:0]              tblWrMode,
  input  logic [DOM_W-1:0]               tblWrMask,
  input  logic [$clog2(CORE_PINS)-1:0]   corePinSel,
  input  logic [AON_PINS-1:0]            aonPins,
  input  logic                           rtcWake,
  input  logic [HBN_IRQS-1:0]            hbnIrq,
  input  logic                           radioTmrWake,
  input  logic                           sleepTmrWake,
  input  logic [CORE_PINS-1:0]           corePins,
  input  logic [AON_PINS+HBN_IRQS+3:0]   evtClr,
  output logic                           hit,
  output logic                           deepMode,
  output logic [AON_PINS+HBN_IRQS+3:0]   evtReg
);

  localparam int SEL_W     = $clog2(CORE_PINS);
  localparam int EVT_W     = AON_PINS + HBN_IRQS + 4;
  localparam int RAW_W     = AON_PINS + 1 + HBN_IRQS + 2 + CORE_PINS;
  localparam int RTC_BIT   = AON_PINS;
  localparam int HBN_LO    = AON_PINS + 1;
  localparam int RADIO_BIT = HBN_LO + HBN_IRQS;
  localparam int STMR_BIT  = RADIO_BIT + 1;
  localparam int PIN_BIT   = RADIO_BIT + 2;

  logic [RAW_W-1:0]     rawVec, syncVec;
  logic [CORE_PINS-1:0] syncCore;
  logic [EVT_W-1:0]     evtVec, enMask, srcMask;
  logic [DOM_W-1:0]     domTbl [NUM_SLOTS];
  logic [SEL_W-1:0]     selQ;
  mode_dec_t            wrDec, curDec;
  logic [SLOT_W-1:0]    effSlot;
  logic                 effDeep;

  // ---------------- input synchronizers ----------------
  assign rawVec = {corePins, sleepTmrWake, radioTmrWake, hbnIrq, rtcWake, aonPins};

  wake_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawVec),
    .dOut (syncVec)
  );

  assign syncCore = syncVec[RAW_W-1 -: CORE_PINS];

  // event vector in register layout
  always_comb begin
    evtVec                           = '0;
    evtVec[AON_PINS-1:0]             = syncVec[AON_PINS-1:0];
    evtVec[RTC_BIT]                  = syncVec[RTC_BIT];
    evtVec[HBN_LO +: HBN_IRQS]       = syncVec[HBN_LO +: HBN_IRQS];
    evtVec[RADIO_BIT]                = syncVec[RADIO_BIT];
    evtVec[STMR_BIT]                 = syncVec[STMR_BIT];
    evtVec[PIN_BIT]                  = syncCore[selQ];
  end

  // ---------------- mode table ----------------
  assign wrDec  = decode_mode(tblWrMode);
  assign curDec = decode_mode(modeCode);

  always_comb begin
    if (curDec.ok) begin
      effSlot = curDec.slot;
      effDeep = curDec.deep;
    end else begin
      effSlot = '0;       // unsupported code acts as sleep level 0
      effDeep = 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_tbl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          domTbl[i] <= '1;
        end else if (tblWrEn && wrDec.ok && (wrDec.slot == SLOT_W'(i))) begin
          domTbl[i] <= tblWrMask;
        end
      end
    end
  endgenerate

  // expand the domain-powered bits into per-source enables
  always_comb begin
    srcMask                       = '0;
    srcMask[AON_PINS-1:0]         = {AON_PINS{domTbl[effSlot][0]}};
    srcMask[RTC_BIT]              = domTbl[effSlot][1];
    srcMask[HBN_LO +: HBN_IRQS]   = {HBN_IRQS{domTbl[effSlot][2]}};
    srcMask[RADIO_BIT]            = domTbl[effSlot][3];
    srcMask[STMR_BIT]             = domTbl[effSlot][3];
    srcMask[PIN_BIT]              = domTbl[effSlot][3];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask   <= '0;
      deepMode <= 1'b0;
      selQ     <= '0;
    end else if (strobes.latchMode) begin
      enMask   <= srcMask;
      deepMode <= effDeep;
      selQ     <= corePinSel;
    end
  end

  assign hit = |(evtVec & enMask);

  // ---------------- sticky event register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtReg <= '0;
    end else begin
      evtReg <= (evtReg & ~evtClr) | (strobes.capture ? (evtVec & enMask) : '0);
    end
  end

  AST_EVT_NO_SET_OUTSIDE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ((evtReg & ~$past(evtReg)) == '0)) else $error("evt set without capture"); // R7

  AST_EVT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> ((evtReg & ~$past(evtReg) & ~$past(enMask)) == '0)) else $error("unenabled evt"); // R2

  AST_CLR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ((evtReg & $past(evtClr)) == '0)) else $error("clear lost"); // R9

endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepReq,
  input  logic         hit,
  input  logic         deepMode,
  output ctrl_strobe_t strobes,
  output logic         wakePulse,
  output logic         cpuReset,
  output logic         sleepActive
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  wake_state_e       state, stateNxt;
  logic [CNT_W-1:0]  rstCnt, rstCntNxt;

  always_comb begin
    stateNxt          = state;
    rstCntNxt         = rstCnt;
    strobes           = '0;
    unique case (state)
      ST_IDLE: begin
        if (sleepReq) begin
          strobes.latchMode = 1'b1;
          stateNxt          = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (hit) begin
          strobes.capture = 1'b1;
          stateNxt        = ST_WAKE;
        end
      end
      ST_WAKE: begin
        rstCntNxt = CNT_W'(1);
        if (deepMode && (RST_CYCLES > 1)) stateNxt = ST_RSTHOLD;
        else                              stateNxt = ST_IDLE;
      end
      ST_RSTHOLD: begin
        if (rstCnt >= CNT_W'(RST_CYCLES - 1)) stateNxt = ST_IDLE;
        else                                  rstCntNxt = rstCnt + CNT_W'(1);
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rstCnt <= '0;
    end else begin
      state  <= stateNxt;
      rstCnt <= rstCntNxt;
    end
  end

  assign wakePulse   = (state == ST_WAKE);
  assign cpuReset    = ((state == ST_WAKE) && deepMode) || (state == ST_RSTHOLD);
  assign sleepActive = (state == ST_SLEEP);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && sleepReq |=> sleepActive) else $error("sleep not entered"); // R1

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse) else $error("wake pulse too long"); // R4

  AST_NO_WAKE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> !wakePulse) else $error("wake without sleep"); // R7

  AST_RESET_STARTS_WITH_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuReset) |-> wakePulse) else $error("reset outside wake"); // R5

  AST_SHALLOW_NO_RESET: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse && !deepMode |=> !cpuReset) else $error("shallow wake reset"); // R4

endmodule

// File: rtl/wake_reset_ctrl.sv
module wake_reset_ctrl
  import wake_pkg::*;
#(
  parameter int AON_PINS    = 4,
  parameter int HBN_IRQS    = 4,
  parameter int CORE_PINS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sleepReq,
  input  logic [5:0]                    modeCode,
  input  logic                          tblWrEn,
  input  logic [5:0]                    tblWrMode,
  input  logic [3:0]                    tblWrMask,
  input  logic [$clog2(CORE_PINS)-1:0]  corePinSel,
  input  logic [AON_PINS-1:0]           aonPins,
  input  logic                          rtcWake,
  input  logic [HBN_IRQS-1:0]           hbnIrq,
  input  logic                          radioTmrWake,
  input  logic                          sleepTmrWake,
  input  logic [CORE_PINS-1:0]          corePins,
  input  logic [AON_PINS+HBN_IRQS+3:0]  evtClr,
  output logic                          wakePulse,
  output logic                          cpuReset,
  output logic                          sleepActive,
  output logic [AON_PINS+HBN_IRQS+3:0]  evtReg
);

  ctrl_strobe_t strobes;
  logic         hit;
  logic         deepMode;

  wake_control #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sleepReq    (sleepReq),
    .hit         (hit),
    .deepMode    (deepMode),
    .strobes     (strobes),
    .wakePulse   (wakePulse),
    .cpuReset    (cpuReset),
    .sleepActive (sleepActive)
  );

  wake_datapath #(
    .AON_PINS    (AON_PINS),
    .HBN_IRQS    (HBN_IRQS),
    .CORE_PINS   (CORE_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .modeCode     (modeCode),
    .tblWrEn      (tblWrEn),
    .tblWrMode    (tblWrMode),
    .tblWrMask    (tblWrMask),
    .corePinSel   (corePinSel),
    .aonPins      (aonPins),
    .rtcWake      (rtcWake),
    .hbnIrq       (hbnIrq),
    .radioTmrWake (radioTmrWake),
    .sleepTmrWake (sleepTmrWake),
    .corePins     (corePins),
    .evtClr       (evtClr),
    .hit          (hit),
    .deepMode     (deepMode),
    .evtReg       (evtReg)
  );

  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakePulse) |-> $past(sleepActive)) else $error("wake not from sleep"); // R7

endmodule

// File: tb/sim_wake_reset_ctrl.sv
module sim_wake_reset_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sleepReq = 1'b0;
  logic [5:0]  modeCode = '0;
  logic        tblWrEn = 1'b0;
  logic [5:0]  tblWrMode = '0;
  logic [3:0]  tblWrMask = '0;
  logic [2:0]  corePinSel = '0;
  logic [3:0]  aonPins = '0;
  logic        rtcWake = 1'b0;
  logic [3:0]  hbnIrq = '0;
  logic        radioTmrWake = 1'b0;
  logic        sleepTmrWake = 1'b0;
  logic [7:0]  corePins = '0;
  logic [11:0] evtClr = '0;
  logic        wakePulse, cpuReset, sleepActive;
  logic [11:0] evtReg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  wake_reset_ctrl u0 (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .modeCode(modeCode),
    .tblWrEn(tblWrEn), .tblWrMode(tblWrMode), .tblWrMask(tblWrMask),
    .corePinSel(corePinSel), .aonPins(aonPins), .rtcWake(rtcWake),
    .hbnIrq(hbnIrq), .radioTmrWake(radioTmrWake), .sleepTmrWake(sleepTmrWake),
    .corePins(corePins), .evtClr(evtClr), .wakePulse(wakePulse),
    .cpuReset(cpuReset), .sleepActive(sleepActive), .evtReg(evtReg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic quiet_inputs();
    aonPins = '0; rtcWake = 0; hbnIrq = '0; radioTmrWake = 0;
    sleepTmrWake = 0; corePins = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_tbl(input logic [5:0] m, input logic [3:0] mask);
    @(negedge clk);
    tblWrEn = 1; tblWrMode = m; tblWrMask = mask;
    @(negedge clk);
    tblWrEn = 0;
  endtask

  task automatic go_sleep(input logic [5:0] m, input string req);
    @(negedge clk);
    modeCode = m; sleepReq = 1;
    @(negedge clk);
    sleepReq = 0;
    check(sleepActive === 1'b1, req, sleepActive, 1);
  endtask

  // called right after the wake input is driven at a falling edge
  task automatic measure(output int lat, output int rl);
    lat = 0; rl = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!wakePulse && lat < 20);
    if (cpuReset) rl = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(wakePulse === 1'b0, "R4 single-cycle wake pulse", wakePulse, 0);
      if (cpuReset) rl++;
    end
  endtask

  task automatic clear_evt(input logic [11:0] m);
    @(negedge clk);
    evtClr = m;
    @(negedge clk);
    evtClr = '0;
  endtask

  task automatic t_reset();
    check(evtReg === 12'h000, "R8 reset event register", evtReg, 0);
    check(wakePulse === 1'b0, "R4 reset wakePulse", wakePulse, 0);
    check(cpuReset === 1'b0, "R5 reset cpuReset", cpuReset, 0);
    check(sleepActive === 1'b0, "R1 reset sleepActive", sleepActive, 0);
  endtask

  task automatic t_shallow();
    int lat, rl;
    go_sleep(6'd2, "R1 enter sleep 2");
    aonPins[1] = 1;
    measure(lat, rl);
    check(lat == 3, "R6 sync latency", lat, 3);
    check(rl == 0, "R4 no reset from sleep 2", rl, 0);
    check(evtReg === 12'h002, "R8 aon pin 1 bit", evtReg, 12'h002);
    check(sleepActive === 1'b0, "R4 back to idle", sleepActive, 0);
    quiet_inputs();
    clear_evt(12'h002);
    check(evtReg === 12'h000, "R9 clear single bit", evtReg, 0);
  endtask

  task automatic t_deep();
    int lat, rl;
    go_sleep(6'd5, "R1 enter sleep 5");
    rtcWake = 1;
    measure(lat, rl);
    check(rl == 4, "R5 reset length sleep 5", rl, 4);
    check(evtReg === 12'h010, "R8 rtc bit 4", evtReg, 12'h010);
    quiet_inputs(); clear_evt('1);
    go_sleep(6'd31, "R1 enter sleep 31");
    radioTmrWake = 1;
    measure(lat, rl);
    check(rl == 4, "R5 reset length sleep 31", rl, 4);
    check(evtReg === 12'h200, "R8 radio timer bit 9", evtReg, 12'h200);
    quiet_inputs(); clear_evt('1);
    go_sleep(6'b100001, "R1 enter hibernate 1");
    hbnIrq[2] = 1;
    measure(lat, rl);
    check(rl == 4, "R3 hibernate 1 resets", rl, 4);
    check(evtReg === 12'h080, "R8 comparator 0 bit 7", evtReg, 12'h080);
    quiet_inputs(); clear_evt('1);
    go_sleep(6'd3, "R1 enter sleep 3");
    sleepTmrWake = 1;
    measure(lat, rl);
    check(rl == 0, "R4 sleep 3 no reset", rl, 0);
    check(evtReg === 12'h400, "R8 sleep timer bit 10", evtReg, 12'h400);
    quiet_inputs(); clear_evt('1);
  endtask

  task automatic t_mask();
    int lat, rl;
    write_tbl(6'd6, 4'b0011);
    go_sleep(6'd6, "R1 enter sleep 6");
    sleepTmrWake = 1; hbnIrq[0] = 1;
    repeat (6) @(negedge clk);
    check(wakePulse === 1'b0 && sleepActive === 1'b1, "R2 unpowered domains do not wake",
          sleepActive, 1);
    aonPins[3] = 1;
    measure(lat, rl);
    check(evtReg === 12'h008, "R2 only enabled bit captured", evtReg, 12'h008);
    check(rl == 4, "R5 sleep 6 reset", rl, 4);
    quiet_inputs(); clear_evt('1);
    write_tbl(6'd6, 4'b1111);
  endtask

  task automatic t_unsupported();
    int lat, rl;
    write_tbl(6'd0, 4'b0100);
    write_tbl(6'b101000, 4'b0000);    // unsupported hibernate 8: ignored
    go_sleep(6'd12, "R1 enter unsupported 12");
    rtcWake = 1;
    repeat (6) @(negedge clk);
    check(sleepActive === 1'b1, "R3 unsupported uses sleep 0 entry", sleepActive, 1);
    hbnIrq[1] = 1;
    measure(lat, rl);
    check(rl == 0, "R3 unsupported no reset", rl, 0);
    check(evtReg === 12'h040, "R3 brown-out bit 6", evtReg, 12'h040);
    quiet_inputs(); clear_evt('1);
    go_sleep(6'b100000, "R10 enter hibernate 0");
    aonPins[0] = 1;
    measure(lat, rl);
    check(evtReg === 12'h001, "R10 ignored write left hibernate 0 intact", evtReg, 12'h001);
    quiet_inputs(); clear_evt('1);
    write_tbl(6'd0, 4'b1111);
  endtask

  task automatic t_ignored();
    bit seen = 0;
    aonPins = '1; rtcWake = 1; hbnIrq = '1; radioTmrWake = 1; sleepTmrWake = 1; corePins = '1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (wakePulse || cpuReset) seen = 1;
    end
    check(!seen, "R7 no wake while idle", seen, 0);
    check(evtReg === 12'h000, "R7 no event while idle", evtReg, 0);
    quiet_inputs();
  endtask

  task automatic t_multi();
    int lat, rl;
    go_sleep(6'b100000, "R1 enter hibernate 0");
    hbnIrq[1] = 1; aonPins[0] = 1;
    measure(lat, rl);
    check(evtReg === 12'h041, "R8 two sources captured", evtReg, 12'h041);
    quiet_inputs();
    clear_evt(12'h001);
    check(evtReg === 12'h040, "R9 partial clear keeps other bit", evtReg, 12'h040);
    clear_evt(12'h040);
    check(evtReg === 12'h000, "R9 second clear", evtReg, 0);
  endtask

  task automatic t_pinsel();
    int lat, rl;
    corePinSel = 3'd5;
    go_sleep(6'd1, "R1 enter sleep 1");
    corePins[2] = 1;
    repeat (6) @(negedge clk);
    check(sleepActive === 1'b1, "R11 unselected pin ignored", sleepActive, 1);
    corePins[5] = 1;
    measure(lat, rl);
    check(lat == 3, "R11 selected pin wakes", lat, 3);
    check(evtReg === 12'h800, "R11 pin bit 11", evtReg, 12'h800);
    quiet_inputs(); clear_evt('1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_shallow();
    t_deep();
    t_mask();
    t_unsupported();
    t_ignored();
    t_multi();
    t_pinsel();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule